// File: doc/BRIEF.md
# Indexed Display Register File with Write Filtering

This block holds the sequencer, CRT controller and attribute controller registers of an extended VGA-style display controller. Each of the three banks is reached through a pair of port addresses: one latches an index, the other reads or writes the register that index selects. Most registers store exactly what is written. A handful of indices rewrite, mask or refuse the incoming byte, and some of the stored values drive side outputs.

The side outputs are an extension-unlock flag, a memory-size field that always reports the configured memory size, and the size, vertical offset and base address of a hardware cursor. The cursor base sits in the top 16 KB of display memory and moves in 256-byte steps. Two generations are built from one source. A parameter picks the generation, and that choice decides which register carries the memory-size field. A second parameter sets the memory size.

Top module: `vgx_regfile`

## Requirements
- R1: After reset every index reads 0 and every data register reads 0. The exceptions are sequencer register 0x06, which reads 0x0F, and the memory-size register. On the older generation that is sequencer 0x0A, which reads the size code in bits 4:3. On the newer generation it is sequencer 0x15, which reads the size code in bits 2:0.
- R2: A write to an index port stores the byte truncated to the bank's index width: 5 bits for the sequencer, 6 bits for the CRT controller, 6 bits for the attribute controller. Reading the index port returns that index, zero-extended.
- R3: A write to sequencer register 0x06 stores 0x12 when (data AND 0x17) equals 0x12, and stores 0x0F otherwise. `unlock_ok` is high exactly when that register holds 0x12.
- R4: On the older generation, a write to sequencer 0x0A stores (data AND 0xE7) with bits 4:3 forced to the size code: 01 for 512 KB, 10 for 1 MB, 11 for 2 MB. On the newer generation, 0x0A stores data unchanged.
- R5: On the newer generation, a write to sequencer 0x15 stores (data AND 0xF8) with bits 2:0 forced to the size code: 2 for 1 MB, 3 for 2 MB, 4 for 4 MB. On the older generation, writes to 0x15 are ignored and it keeps reading 0.
- R6: Bit 2 of sequencer 0x12 selects the large cursor. When it is set, `curs_dim` is 64 and `curs_yoff` is 0. When it is clear, `curs_dim` is 32 and `curs_yoff` is 32.
- R7: `curs_base` equals the memory size minus 0x4000, plus 256 times (sequencer 0x13 AND M). M is 0x3C for the large cursor and 0x3F for the small one. The value is updated on the clock edge that writes 0x12 or 0x13.
- R8: Writes to CRT registers 0x25 and 0x27 are discarded, so both keep reading 0.
- R9: While bit 7 of CRT register 0x11 is set, a write to CRT register 0x07 changes only its bit 4.
- R10: An attribute data write is stored only when the attribute index is below 0x20 or at least 0x30. Writes to indices 0x20 through 0x2F leave the register unchanged.
- R11: All other data registers store the written byte unchanged. `rd_data` combinationally shows the selected port's value, and reading changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected port |
| port_sel | input | 3 | Port select: 0 seq index, 1 seq data, 2 CRT index, 3 CRT data, 4 attr index, 5 attr data, 6-7 unused (read 0, writes ignored) |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Value of the selected port |
| unlock_ok | output | 1 | Extensions unlocked |
| curs_large | output | 1 | Large cursor selected |
| curs_dim | output | 7 | Cursor width and height in pixels |
| curs_yoff | output | 6 | Cursor vertical offset |
| curs_base | output | ADDR_W | Cursor base byte address, ADDR_W = log2(memory bytes) |

## Verification
The assertions assume that `port_sel` and `wr_data` are known whenever `wr_en` is high. They also assume the index a data write uses is the one latched by an earlier index write, never one written in the same cycle. The stimulus drives every input once per cycle, just after a rising edge, and issues one access per cycle. An index write is always followed by the data access in a later cycle. Both generations are driven with the same sequence, so the generation-specific memory-size rules are checked side by side.

// File: rtl/vgx_pkg.sv
package vgx_pkg;

   typedef enum logic [2:0] {
      PS_SEQ_IDX = 3'd0,
      PS_SEQ_DAT = 3'd1,
      PS_CRT_IDX = 3'd2,
      PS_CRT_DAT = 3'd3,
      PS_ATR_IDX = 3'd4,
      PS_ATR_DAT = 3'd5
   } vgx_port_e;

   // sequencer indices with a write rule
   localparam int IX_UNLOCK = 'h06;
   localparam int IX_MEMOLD = 'h0A;
   localparam int IX_CCTL   = 'h12;
   localparam int IX_CSEL   = 'h13;
   localparam int IX_MEMNEW = 'h15;

   // CRT indices with a write rule
   localparam int IX_CR_PROT = 'h11;
   localparam int IX_CR_VOVF = 'h07;
   localparam int IX_CR_RO_A = 'h25;
   localparam int IX_CR_RO_B = 'h27;

   localparam logic [7:0] KEY_OPEN = 8'h12;
   localparam logic [7:0] KEY_SHUT = 8'h0F;

   function automatic logic [2:0] mem_size_code(int gen_new, int mem_kb);
      if (gen_new != 0)
         return (mem_kb == 1024) ? 3'd2 : (mem_kb == 2048) ? 3'd3 : 3'd4;
      return (mem_kb == 512) ? 3'd1 : (mem_kb == 1024) ? 3'd2 : 3'd3;
   endfunction

   function automatic bit mem_cfg_ok(int gen_new, int mem_kb);
      if (gen_new != 0)
         return (mem_kb == 1024) || (mem_kb == 2048) || (mem_kb == 4096);
      return (mem_kb == 512) || (mem_kb == 1024) || (mem_kb == 2048);
   endfunction

endpackage

// File: rtl/vgx_seq_bank.sv
module vgx_seq_bank
   import vgx_pkg::*;
#(
   parameter int GEN_NEW = 0,
   parameter int MEM_KB  = 1024,
   parameter int IDX_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_we,
   input  logic             dat_we,
   input  logic [7:0]       wdata,
   output logic [IDX_W-1:0] idx_o,
   output logic [7:0]       rdata,
   output logic             unlock_o,
   output logic [7:0]       memreg_o,
   output logic             cur_we_o,
   output logic [7:0]       ctl_nxt_o,
   output logic [7:0]       sel_nxt_o
);
   localparam int         DEPTH   = 1 << IDX_W;
   localparam logic [2:0] CODE    = mem_size_code(GEN_NEW, MEM_KB);
   localparam int         MEM_IDX = (GEN_NEW != 0) ? IX_MEMNEW : IX_MEMOLD;
   localparam logic [7:0] MEM_RST = (GEN_NEW != 0) ? {5'b0, CODE} : {3'b0, CODE[1:0], 3'b0};

   logic [IDX_W-1:0] idx_q;
   logic [7:0]       regs_q [DEPTH];
   logic [7:0]       memf;
   logic             drop;
   logic [7:0]       nxt;

   function automatic logic [7:0] rst_val(int i);
      if (i == IX_UNLOCK) return KEY_SHUT;
      if (i == MEM_IDX)   return MEM_RST;
      return 8'h00;
   endfunction

   generate
      if (GEN_NEW != 0) begin : g_new
         assign memf = (wdata & 8'hF8) | {5'b0, CODE};
         assign drop = 1'b0;
      end else begin : g_old
         assign memf = (wdata & 8'hE7) | {3'b0, CODE[1:0], 3'b0};
         assign drop = (idx_q == IDX_W'(IX_MEMNEW));
      end
   endgenerate

   always_comb begin
      nxt = wdata;
      if (idx_q == IDX_W'(IX_UNLOCK))
         nxt = ((wdata & 8'h17) == KEY_OPEN) ? KEY_OPEN : KEY_SHUT;
      else if (idx_q == IDX_W'(MEM_IDX))
         nxt = memf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < DEPTH; i++) regs_q[i] <= rst_val(i);
      end else begin
         if (idx_we) idx_q <= wdata[IDX_W-1:0];
         if (dat_we && !drop) regs_q[idx_q] <= nxt;
      end
   end

   assign idx_o     = idx_q;
   assign rdata     = regs_q[idx_q];
   assign unlock_o  = (regs_q[IX_UNLOCK] == KEY_OPEN);
   assign memreg_o  = regs_q[MEM_IDX];
   assign cur_we_o  = dat_we && ((idx_q == IDX_W'(IX_CCTL)) || (idx_q == IDX_W'(IX_CSEL)));
   assign ctl_nxt_o = (dat_we && idx_q == IDX_W'(IX_CCTL)) ? nxt : regs_q[IX_CCTL];
   assign sel_nxt_o = (dat_we && idx_q == IDX_W'(IX_CSEL)) ? nxt : regs_q[IX_CSEL];
endmodule

// File: rtl/vgx_crt_bank.sv
module vgx_crt_bank
   import vgx_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_we,
   input  logic             dat_we,
   input  logic [7:0]       wdata,
   output logic [IDX_W-1:0] idx_o,
   output logic [7:0]       rdata,
   output logic             prot_o,
   output logic [7:0]       r7_o,
   output logic [7:0]       ro_a_o,
   output logic [7:0]       ro_b_o
);
   localparam int DEPTH = 1 << IDX_W;

   logic [IDX_W-1:0] idx_q;
   logic [7:0]       regs_q [DEPTH];
   logic             drop;
   logic [7:0]       nxt;

   assign prot_o = regs_q[IX_CR_PROT][7];
   assign drop   = (idx_q == IDX_W'(IX_CR_RO_A)) || (idx_q == IDX_W'(IX_CR_RO_B));

   always_comb begin
      nxt = wdata;
      if (idx_q == IDX_W'(IX_CR_VOVF) && prot_o)
         nxt = (regs_q[IX_CR_VOVF] & 8'hEF) | (wdata & 8'h10);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < DEPTH; i++) regs_q[i] <= 8'h00;
      end else begin
         if (idx_we) idx_q <= wdata[IDX_W-1:0];
         if (dat_we && !drop) regs_q[idx_q] <= nxt;
      end
   end

   assign idx_o  = idx_q;
   assign rdata  = regs_q[idx_q];
   assign r7_o   = regs_q[IX_CR_VOVF];
   assign ro_a_o = regs_q[IX_CR_RO_A];
   assign ro_b_o = regs_q[IX_CR_RO_B];
endmodule

// File: rtl/vgx_attr_bank.sv
module vgx_attr_bank #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_we,
   input  logic             dat_we,
   input  logic [7:0]       wdata,
   output logic [IDX_W-1:0] idx_o,
   output logic [7:0]       rdata
);
   localparam int DEPTH    = 1 << IDX_W;
   localparam int GAP_LO   = 'h20;
   localparam int GAP_HI   = 'h30;

   logic [IDX_W-1:0] idx_q;
   logic [7:0]       regs_q [DEPTH];
   logic             take;

   assign take = (idx_q < IDX_W'(GAP_LO)) || (idx_q >= IDX_W'(GAP_HI));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < DEPTH; i++) regs_q[i] <= 8'h00;
      end else begin
         if (idx_we) idx_q <= wdata[IDX_W-1:0];
         if (dat_we && take) regs_q[idx_q] <= wdata;
      end
   end

   assign idx_o = idx_q;
   assign rdata = regs_q[idx_q];
endmodule

// File: rtl/vgx_cursor.sv
module vgx_cursor #(
   parameter int MEM_KB = 1024,
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [7:0]        ctl,
   input  logic [7:0]        sel,
   output logic              large_o,
   output logic [6:0]        dim_o,
   output logic [5:0]        yoff_o,
   output logic [ADDR_W-1:0] base_o
);
   localparam logic [ADDR_W-1:0] BASE0 = ADDR_W'(MEM_KB * 1024 - 'h4000);
   localparam int                LARGE_BIT = 2;

   logic       big;
   logic [5:0] sel_m;

   assign big   = ctl[LARGE_BIT];
   assign sel_m = big ? (sel[5:0] & 6'h3C) : sel[5:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         large_o <= 1'b0;
         dim_o   <= 7'd32;
         yoff_o  <= 6'd32;
         base_o  <= BASE0;
      end else if (upd) begin
         large_o <= big;
         dim_o   <= big ? 7'd64 : 7'd32;
         yoff_o  <= big ? 6'd0 : 6'd32;
         base_o  <= BASE0 + ADDR_W'({sel_m, 8'h00});
      end
   end
endmodule

// File: rtl/vgx_regfile.sv
module vgx_regfile
   import vgx_pkg::*;
#(
   parameter  int GEN_NEW   = 0,
   parameter  int MEM_KB    = 1024,
   parameter  int SEQ_IDX_W = 5,
   parameter  int CRT_IDX_W = 6,
   parameter  int ATR_IDX_W = 6,
   localparam int ADDR_W    = $clog2(MEM_KB * 1024)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        port_sel,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   output logic              unlock_ok,
   output logic              curs_large,
   output logic [6:0]        curs_dim,
   output logic [5:0]        curs_yoff,
   output logic [ADDR_W-1:0] curs_base
);
   generate
      if (!mem_cfg_ok(GEN_NEW, MEM_KB)) begin : g_bad_mem
         $error("memory size not supported by the selected generation");
      end
      if (SEQ_IDX_W < 5 || SEQ_IDX_W > 8) begin : g_bad_seq
         $error("sequencer index width must be 5 to 8");
      end
      if (CRT_IDX_W < 6 || CRT_IDX_W > 8) begin : g_bad_crt
         $error("CRT index width must be 6 to 8");
      end
      if (ATR_IDX_W < 6 || ATR_IDX_W > 8) begin : g_bad_atr
         $error("attribute index width must be 6 to 8");
      end
   endgenerate

   vgx_port_e psel;
   assign psel = vgx_port_e'(port_sel);

   logic [SEQ_IDX_W-1:0] seq_idx;
   logic [CRT_IDX_W-1:0] crt_idx;
   logic [ATR_IDX_W-1:0] atr_idx;
   logic [7:0]           seq_rd, crt_rd, atr_rd;
   logic [7:0]           memreg, ctl_nxt, sel_nxt;
   logic                 cur_we, crt_prot;
   logic [7:0]           crt_r7, crt_ro_a, crt_ro_b;

   vgx_seq_bank #(.GEN_NEW(GEN_NEW), .MEM_KB(MEM_KB), .IDX_W(SEQ_IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .idx_we(wr_en && psel == PS_SEQ_IDX), .dat_we(wr_en && psel == PS_SEQ_DAT),
      .wdata(wr_data), .idx_o(seq_idx), .rdata(seq_rd), .unlock_o(unlock_ok),
      .memreg_o(memreg), .cur_we_o(cur_we), .ctl_nxt_o(ctl_nxt), .sel_nxt_o(sel_nxt)
   );

   vgx_crt_bank #(.IDX_W(CRT_IDX_W)) u_crt (
      .clk(clk), .rst_n(rst_n),
      .idx_we(wr_en && psel == PS_CRT_IDX), .dat_we(wr_en && psel == PS_CRT_DAT),
      .wdata(wr_data), .idx_o(crt_idx), .rdata(crt_rd), .prot_o(crt_prot),
      .r7_o(crt_r7), .ro_a_o(crt_ro_a), .ro_b_o(crt_ro_b)
   );

   vgx_attr_bank #(.IDX_W(ATR_IDX_W)) u_atr (
      .clk(clk), .rst_n(rst_n),
      .idx_we(wr_en && psel == PS_ATR_IDX), .dat_we(wr_en && psel == PS_ATR_DAT),
      .wdata(wr_data), .idx_o(atr_idx), .rdata(atr_rd)
   );

   vgx_cursor #(.MEM_KB(MEM_KB), .ADDR_W(ADDR_W)) u_cur (
      .clk(clk), .rst_n(rst_n), .upd(cur_we), .ctl(ctl_nxt), .sel(sel_nxt),
      .large_o(curs_large), .dim_o(curs_dim), .yoff_o(curs_yoff), .base_o(curs_base)
   );

   always_comb begin
      case (psel)
         PS_SEQ_IDX: rd_data = 8'(seq_idx);
         PS_SEQ_DAT: rd_data = seq_rd;
         PS_CRT_IDX: rd_data = 8'(crt_idx);
         PS_CRT_DAT: rd_data = crt_rd;
         PS_ATR_IDX: rd_data = 8'(atr_idx);
         PS_ATR_DAT: rd_data = atr_rd;
         default:    rd_data = 8'h00;
      endcase
   end
endmodule

// File: rtl/vgx_regfile_chk.sv
module vgx_regfile_chk
   import vgx_pkg::*;
#(
   parameter int GEN_NEW   = 0,
   parameter int MEM_KB    = 1024,
   parameter int SEQ_IDX_W = 5,
   parameter int CRT_IDX_W = 6,
   parameter int ADDR_W    = 20
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [2:0]           port_sel,
   input logic [7:0]           wr_data,
   input logic [SEQ_IDX_W-1:0] seq_idx,
   input logic [CRT_IDX_W-1:0] crt_idx,
   input logic                 unlock_ok,
   input logic [7:0]           memreg,
   input logic                 crt_prot,
   input logic [7:0]           crt_r7,
   input logic [7:0]           crt_ro_a,
   input logic [7:0]           crt_ro_b,
   input logic                 curs_large,
   input logic [6:0]           curs_dim,
   input logic [5:0]           curs_yoff,
   input logic [ADDR_W-1:0]    curs_base
);
   localparam logic [2:0]    CODE  = mem_size_code(GEN_NEW, MEM_KB);
   localparam logic [ADDR_W:0] FLOOR = (ADDR_W + 1)'(MEM_KB * 1024 - 'h4000);

   // R3: unlock flag follows the key rule of the last write to index 0x06
   p_unlock_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel == 3'd1 && seq_idx == SEQ_IDX_W'(IX_UNLOCK))
      |=> (unlock_ok == (($past(wr_data) & 8'h17) == KEY_OPEN)));

   // R4 / R5: size field always reports the configured size
   generate
      if (GEN_NEW != 0) begin : g_new
         p_memsize_r5: assert property (@(posedge clk) disable iff (!rst_n)
            memreg[2:0] == CODE);
      end else begin : g_old
         p_memsize_r4: assert property (@(posedge clk) disable iff (!rst_n)
            memreg[4:3] == CODE[1:0]);
      end
   endgenerate

   // R6: cursor geometry pairs
   p_cursor_geom_r6: assert property (@(posedge clk) disable iff (!rst_n)
      curs_large ? (curs_dim == 7'd64 && curs_yoff == 6'd0)
                 : (curs_dim == 7'd32 && curs_yoff == 6'd32));

   // R7: base stays 256-aligned inside the top 16 KB
   p_cursor_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
      curs_base[7:0] == 8'h00 && {1'b0, curs_base} >= FLOOR);

   // R8: read-only CRT registers never change from reset
   p_crt_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
      crt_ro_a == 8'h00 && crt_ro_b == 8'h00);

   // R9: protected write to CRT 0x07 keeps all bits but bit 4
   p_crt7_prot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel == 3'd3 && crt_idx == CRT_IDX_W'(IX_CR_VOVF) && crt_prot)
      |=> ((crt_r7 & 8'hEF) == ($past(crt_r7) & 8'hEF)));
endmodule

bind vgx_regfile vgx_regfile_chk #(
   .GEN_NEW(GEN_NEW), .MEM_KB(MEM_KB), .SEQ_IDX_W(SEQ_IDX_W),
   .CRT_IDX_W(CRT_IDX_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data),
   .seq_idx(seq_idx), .crt_idx(crt_idx), .unlock_ok(unlock_ok), .memreg(memreg),
   .crt_prot(crt_prot), .crt_r7(crt_r7), .crt_ro_a(crt_ro_a), .crt_ro_b(crt_ro_b),
   .curs_large(curs_large), .curs_dim(curs_dim), .curs_yoff(curs_yoff),
   .curs_base(curs_base)
);

// File: tb/vgx_regfile_bench.sv
`timescale 1ns/1ps
module vgx_regfile_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] port_sel = 3'd0;
   logic [7:0] wr_data = 8'h00;

   always #2 clk = ~clk;

   logic [7:0]  rd_o, rd_n;
   logic        unl_o, unl_n, lg_o, lg_n;
   logic [6:0]  dim_o, dim_n;
   logic [5:0]  yo_o, yo_n;
   logic [19:0] base_o;
   logic [21:0] base_n;

   // older generation, 1 MB (size code 2)
   vgx_regfile #(.GEN_NEW(0), .MEM_KB(1024)) u_vgx_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data),
      .rd_data(rd_o), .unlock_ok(unl_o), .curs_large(lg_o), .curs_dim(dim_o),
      .curs_yoff(yo_o), .curs_base(base_o));

   // newer generation, 4 MB (size code 4)
   vgx_regfile #(.GEN_NEW(1), .MEM_KB(4096)) u_vgx_regfile_new (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .port_sel(port_sel), .wr_data(wr_data),
      .rd_data(rd_n), .unlock_ok(unl_n), .curs_large(lg_n), .curs_dim(dim_n),
      .curs_yoff(yo_n), .curs_base(base_n));

   int    n_chk = 0;
   int    n_err = 0;
   string cur_req = "R1";
   bit    live = 1'b0;
   bit    done = 1'b0;

   int sq [2][32];
   int cr [2][64];
   int at [2][64];
   int si, ci, ai;
   int memtop [2] = '{32'h100000, 32'h400000};

   task automatic chk(string r, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", r, act, exp);
      end
   endtask

   // reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 32; i++) sq[k][i] = 0;
            for (int i = 0; i < 64; i++) begin cr[k][i] = 0; at[k][i] = 0; end
            sq[k][6] = 'h0F;
         end
         sq[0]['h0A] = 'h10;
         sq[1]['h15] = 'h04;
         si = 0; ci = 0; ai = 0;
         live = 1'b1;
      end else if (wr_en) begin
         case (int'(port_sel))
            0: si = int'(wr_data) & 31;
            2: ci = int'(wr_data) & 63;
            4: ai = int'(wr_data) & 63;
            1: for (int k = 0; k < 2; k++) begin
                  if (si == 6)
                     sq[k][6] = ((int'(wr_data) & 'h17) == 'h12) ? 'h12 : 'h0F;
                  else if (si == 'h0A && k == 0)
                     sq[k][si] = (int'(wr_data) & 'hE7) | 'h10;
                  else if (si == 'h15) begin
                     if (k == 1) sq[k][si] = (int'(wr_data) & 'hF8) | 4;
                  end else
                     sq[k][si] = int'(wr_data);
               end
            3: for (int k = 0; k < 2; k++) begin
                  if (ci == 'h25 || ci == 'h27) begin end
                  else if (ci == 7 && (cr[k]['h11] & 'h80) != 0)
                     cr[k][7] = (cr[k][7] & 'hEF) | (int'(wr_data) & 'h10);
                  else
                     cr[k][ci] = int'(wr_data);
               end
            5: for (int k = 0; k < 2; k++)
                  if (ai < 'h20 || ai >= 'h30) at[k][ai] = int'(wr_data);
            default: ;
         endcase
      end
   end

   function automatic int exp_rd(int k);
      case (int'(port_sel))
         0: return si;
         1: return sq[k][si];
         2: return ci;
         3: return cr[k][ci];
         4: return ai;
         5: return at[k][ai];
         default: return 0;
      endcase
   endfunction

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (live && !done) begin
         chk(cur_req, int'(rd_o), exp_rd(0));
         chk(cur_req, int'(rd_n), exp_rd(1));
         for (int k = 0; k < 2; k++) begin
            int lg, ab, ad, ay, abase;
            lg = (sq[k]['h12] >> 2) & 1;
            ab = (k == 0) ? int'(lg_o) : int'(lg_n);
            ad = (k == 0) ? int'(dim_o) : int'(dim_n);
            ay = (k == 0) ? int'(yo_o) : int'(yo_n);
            abase = (k == 0) ? int'(base_o) : int'(base_n);
            chk("R3", (k == 0) ? int'(unl_o) : int'(unl_n), (sq[k][6] == 'h12) ? 1 : 0);
            chk("R6", ab, lg);
            chk("R6", ad, (lg != 0) ? 64 : 32);
            chk("R6", ay, (lg != 0) ? 0 : 32);
            chk("R7", abase, memtop[k] - 'h4000 +
                (sq[k]['h13] & ((lg != 0) ? 'h3C : 'h3F)) * 256);
         end
      end
   end

   task automatic op(int p, bit w, int d, string r);
      @(posedge clk);
      #1;
      cur_req  = r;
      port_sel = 3'(p);
      wr_en    = w;
      wr_data  = 8'(d);
   endtask

   // select index, write data, then read it back
   task automatic wrd(int ip, int idx, int d, string r);
      op(ip, 1'b1, idx, r);
      op(ip + 1, 1'b1, d, r);
      op(ip + 1, 1'b0, 0, r);
      op(ip, 1'b0, 0, r);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1: reset values
      op(0, 1'b1, 'h06, "R1"); op(1, 1'b0, 0, "R1");
      op(0, 1'b1, 'h0A, "R1"); op(1, 1'b0, 0, "R1");
      op(0, 1'b1, 'h15, "R1"); op(1, 1'b0, 0, "R1");
      op(2, 1'b0, 0, "R1"); op(3, 1'b0, 0, "R1"); op(5, 1'b0, 0, "R1");
      // R2: index truncation
      op(0, 1'b1, 'hFF, "R2"); op(0, 1'b0, 0, "R2");
      op(2, 1'b1, 'hFF, "R2"); op(2, 1'b0, 0, "R2");
      op(4, 1'b1, 'hC5, "R2"); op(4, 1'b0, 0, "R2");
      op(6, 1'b1, 'h33, "R2"); op(7, 1'b0, 0, "R2");
      // R3: unlock key
      wrd(0, 'h06, 'h12, "R3");
      wrd(0, 'h06, 'h13, "R3");
      wrd(0, 'h06, 'hFA, "R3");
      wrd(0, 'h06, 'h00, "R3");
      wrd(0, 'h06, 'h32, "R3");
      // R4 / R5: memory-size fields
      wrd(0, 'h0A, 'hFF, "R4");
      wrd(0, 'h0A, 'h00, "R4");
      wrd(0, 'h15, 'hFF, "R5");
      wrd(0, 'h15, 'h01, "R5");
      // R6 / R7: cursor
      wrd(0, 'h13, 'hFF, "R7");
      wrd(0, 'h12, 'h04, "R6");
      wrd(0, 'h13, 'h25, "R7");
      wrd(0, 'h12, 'hFB, "R6");
      wrd(0, 'h13, 'h00, "R7");
      // R8: read-only CRT registers
      wrd(2, 'h25, 'hAA, "R8");
      wrd(2, 'h27, 'h5A, "R8");
      wrd(2, 'h26, 'h55, "R11");
      // R9: CRT 0x07 protection
      wrd(2, 'h07, 'hFF, "R9");
      wrd(2, 'h11, 'h80, "R9");
      wrd(2, 'h07, 'h00, "R9");
      wrd(2, 'h07, 'h10, "R9");
      wrd(2, 'h11, 'h00, "R9");
      wrd(2, 'h07, 'h00, "R9");
      // R10: attribute gap
      wrd(4, 'h1F, 'h11, "R10");
      wrd(4, 'h20, 'h22, "R10");
      wrd(4, 'h2F, 'h33, "R10");
      wrd(4, 'h30, 'h44, "R10");
      wrd(4, 'h3F, 'h55, "R10");
      // R11: plain registers and repeated reads
      for (int i = 0; i < 8; i++) wrd(0, 'h18 + i, 'h3C ^ (i * 17), "R11");
      for (int i = 0; i < 4; i++) op(1, 1'b0, 0, "R11");
      wrd(2, 'h3F, 'hA5, "R11");
      op(3, 1'b0, 0, "R11");
      op(3, 1'b0, 0, "R11");
      @(posedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule